// File: doc/BRIEF.md
# Per-Field Calendar Alarm Matcher

This block raises an alarm interrupt for a calendar whose fields are held in BCD. Software programs six alarm values (seconds, minutes, hours, day of month, month, three-digit year) and an alarm control word through a simple register write port. The alarm values can be read back through a combinational read port. The calendar counter lives elsewhere. It presents its current BCD fields to this block together with a one-cycle strobe in the cycle after each one-second advance.

On each strobe, and only while the global alarm enable is set, every field whose match enable is set is compared with its alarm value. A single equal field is enough to fire: the fields are OR-combined, not AND-combined. A firing sets a pending flag, and the alarm interrupt follows that flag. The flag stays set until software writes a one to its bit in the status register. A firing in the same cycle as a clear keeps the flag set.

Top module: `cal_alarm_matcher`

## Requirements
- R1: After reset the control word, all six alarm values and the pending flag read as zero, and `alarm_irq` is low.
- R2: A write to an alarm register keeps only that field's width. Seconds (0x54) and minutes (0x58) keep 7 bits. Hours (0x5C) and day (0x60) keep 6 bits. Month (0x64) keeps 5 bits. Year (0x68) keeps 12 bits. Reads return zero above those widths.
- R3: The control word at 0x50 keeps 7 bits. Bits 0..5 enable matching of seconds, minutes, hours, day, month and year, in that order. Bit 6 is the global enable.
- R4: With bit 6 of the control word clear, a strobe never sets the pending flag, even when enabled fields match.
- R5: With bit 6 set, a strobe sets the pending flag when at least one enabled field equals its alarm value, even if every other enabled field differs.
- R6: A field whose enable bit is clear never causes a firing, whatever its value.
- R7: Equal fields without a strobe never set the pending flag.
- R8: The pending flag is set at the clock edge that samples the strobe. It is visible as bit 1 of the status register at 0x30 and on `alarm_irq`. It stays set until it is cleared.
- R9: A write to 0x30 with bit 1 set clears the pending flag and lowers `alarm_irq`. A write to 0x30 with bit 1 clear leaves the flag unchanged.
- R10: When a firing strobe and a clearing write occur in the same cycle, the pending flag ends up set.
- R11: The year match compares all 12 bits of the three-digit BCD value. A difference only in the hundreds digit is not a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational |
| tick_1hz | input | 1 | One-cycle strobe after each second advance |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_mday | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt, high while pending |

## Verification
The assertions take for granted that the strobe is low throughout reset. They also assume that the calendar fields are stable in the strobe cycle. Under those assumptions, every rise of the interrupt traces back to a strobe and every fall traces back to a clearing write. The stimulus applies the strobe only for a single cycle, and never while reset is high. It never writes an alarm register in the same cycle as a strobe, so each comparison sees settled alarm values. The random part forces roughly a third of the current fields equal to their alarm values, so that both firing and non-firing strobes occur often.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int FIELD_W    = 12;
    localparam int CTRL_W     = 7;
    localparam int PEND_BIT   = 1;

    localparam logic [7:0] OFS_STATUS = 8'h30;
    localparam logic [7:0] OFS_CTRL   = 8'h50;
    localparam logic [7:0] OFS_FIELD0 = 8'h54;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_MDAY = 3'd3,
        FLD_MON  = 3'd4,
        FLD_YEAR = 3'd5
    } field_e;

    typedef struct packed {
        logic                  glob_en;
        logic [NUM_FIELDS-1:0] field_en;
    } alm_ctrl_t;

    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    function automatic int field_width(input int idx);
        case (idx)
            FLD_SEC, FLD_MIN:   return 7;
            FLD_HOUR, FLD_MDAY: return 6;
            FLD_MON:            return 5;
            default:            return 12;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        logic [FIELD_W-1:0] m;
        for (int b = 0; b < FIELD_W; b++) begin
            m[b] = (b < field_width(idx));
        end
        return m;
    endfunction

    function automatic logic [7:0] field_offset(input int idx);
        return OFS_FIELD0 + 8'(4 * idx);
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pending,
    output alm_ctrl_t         ctrl_o,
    output field_vec_t        alm_o,
    output logic              clr_req
);

    alm_ctrl_t ctrl_q;
    field_vec_t alm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(OFS_CTRL)) begin
            ctrl_q <= alm_ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam logic [FIELD_W-1:0] MASK = field_mask(g);
        localparam logic [ADDR_W-1:0]  OFS  = ADDR_W'(field_offset(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                alm_q[g] <= '0;
            end else if (wr_en && wr_addr == OFS) begin
                alm_q[g] <= wr_data[FIELD_W-1:0] & MASK;
            end
        end
    end

    assign clr_req = wr_en && (wr_addr == ADDR_W'(OFS_STATUS)) && wr_data[PEND_BIT];

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_STATUS)) begin
            rd_data[PEND_BIT] = pending;
        end
        if (rd_addr == ADDR_W'(OFS_CTRL)) begin
            rd_data[CTRL_W-1:0] = ctrl_q;
        end
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (rd_addr == ADDR_W'(field_offset(i))) begin
                rd_data[FIELD_W-1:0] = alm_q[i];
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign alm_o  = alm_q;

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
(
    input  logic                  tick,
    input  alm_ctrl_t             ctrl,
    input  field_vec_t            alm,
    input  field_vec_t            cur,
    output logic [NUM_FIELDS-1:0] eq_o,
    output logic                  hit_o
);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_eq
        localparam logic [FIELD_W-1:0] MASK = field_mask(g);
        assign eq_o[g] = ((cur[g] & MASK) == alm[g]);
    end

    assign hit_o = tick && ctrl.glob_en && |(eq_o & ctrl.field_en);

endmodule

// File: rtl/cal_alarm_pending.sv
module cal_alarm_pending (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= 1'b0;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end
    end

endmodule

// File: rtl/cal_alarm_matcher.sv
module cal_alarm_matcher
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick_1hz,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_mday,
    input  logic [4:0]        cur_mon,
    input  logic [11:0]       cur_year,
    output logic              alarm_irq
);

    alm_ctrl_t             ctrl_w;
    field_vec_t            alm_w;
    field_vec_t            cur_w;
    logic [NUM_FIELDS-1:0] eq_w;
    logic                  hit_w;
    logic                  clr_w;
    logic                  pend_w;

    always_comb begin
        cur_w           = '0;
        cur_w[FLD_SEC]  = FIELD_W'(cur_sec);
        cur_w[FLD_MIN]  = FIELD_W'(cur_min);
        cur_w[FLD_HOUR] = FIELD_W'(cur_hour);
        cur_w[FLD_MDAY] = FIELD_W'(cur_mday);
        cur_w[FLD_MON]  = FIELD_W'(cur_mon);
        cur_w[FLD_YEAR] = cur_year;
    end

    cal_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pending (pend_w),
        .ctrl_o  (ctrl_w),
        .alm_o   (alm_w),
        .clr_req (clr_w)
    );

    cal_alarm_cmp u_cmp (
        .tick  (tick_1hz),
        .ctrl  (ctrl_w),
        .alm   (alm_w),
        .cur   (cur_w),
        .eq_o  (eq_w),
        .hit_o (hit_w)
    );

    cal_alarm_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (hit_w),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    assign alarm_irq = pend_w;

endmodule

// File: rtl/cal_alarm_checker.sv
module cal_alarm_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       clr,
    input logic       hit,
    input logic [6:0] ctrl,
    input logic [7:0] rd_addr,
    input logic [31:0] rd_data,
    input logic       irq
);

    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick)) else $error("irq rose without strobe"); // R7

    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(clr)) else $error("irq fell without clear"); // R9

    AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl[6] && !irq) |=> !irq) else $error("fired with global off"); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (hit && clr) |=> irq) else $error("clear beat a firing"); // R10

    AST_HELD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq) else $error("pending dropped by itself"); // R8

    AST_SEC_READ_MASK: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 8'h54) |-> (rd_data[31:7] == '0)) else $error("seconds mask"); // R2

endmodule

bind cal_alarm_matcher cal_alarm_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_1hz),
    .clr     (clr_w),
    .hit     (hit_w),
    .ctrl    (ctrl_w),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (alarm_irq)
);

// File: tb/sim_cal_alarm_matcher.sv
module sim_cal_alarm_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tick_1hz = 1'b0;
    logic [6:0]  cur_sec = '0;
    logic [6:0]  cur_min = '0;
    logic [5:0]  cur_hour = '0;
    logic [5:0]  cur_mday = '0;
    logic [4:0]  cur_mon = '0;
    logic [11:0] cur_year = '0;
    logic        alarm_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] m_alm [6];
    logic [6:0]  m_ctrl;

    always #10 clk = ~clk;

    cal_alarm_matcher u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_1hz(tick_1hz),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_mday(cur_mday), .cur_mon(cur_mon), .cur_year(cur_year),
        .alarm_irq(alarm_irq)
    );

    function automatic logic [11:0] exp_mask(input int i);
        case (i)
            0, 1:    return 12'h07F;
            2, 3:    return 12'h03F;
            4:       return 12'h01F;
            default: return 12'hFFF;
        endcase
    endfunction

    function automatic logic exp_fire(input logic [6:0] c, input logic [11:0] t [6]);
        logic any = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (c[i] && ((t[i] & exp_mask(i)) == m_alm[i])) any = 1'b1;
        end
        return c[6] && any;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h50) m_ctrl = d[6:0];
        for (int i = 0; i < 6; i++) if (a == 8'h54 + 8'(4*i)) m_alm[i] = d[11:0] & exp_mask(i);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_time(input logic [11:0] t [6]);
        cur_sec = t[0][6:0]; cur_min = t[1][6:0]; cur_hour = t[2][5:0];
        cur_mday = t[3][5:0]; cur_mon = t[4][4:0]; cur_year = t[5];
    endtask

    task automatic strobe(input logic [11:0] t [6]);
        @(negedge clk);
        set_time(t);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [11:0] t [6];
        void'($urandom(32'd5150));
        m_ctrl = '0;
        for (int i = 0; i < 6; i++) m_alm[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(alarm_irq), 32'd0);
        rd(8'h50, d); chk("R1 ctrl", d, 0);
        rd(8'h30, d); chk("R1 status", d, 0);
        for (int i = 0; i < 6; i++) begin
            rd(8'h54 + 8'(4*i), d); chk("R1 alarm reg", d, 0);
        end

        // R2 / R3 masking
        for (int i = 0; i < 6; i++) begin
            wr(8'h54 + 8'(4*i), 32'hFFFF_FFFF);
            rd(8'h54 + 8'(4*i), d); chk("R2 mask", d, 32'(exp_mask(i)));
        end
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, d); chk("R3 ctrl mask", d, 32'h7F);

        // base alarm: 12:34:56 day 15 month 06 year 0x123
        wr(8'h54, 32'h56); wr(8'h58, 32'h34); wr(8'h5C, 32'h12);
        wr(8'h60, 32'h15); wr(8'h64, 32'h06); wr(8'h68, 32'h123);

        // R4 global enable off
        wr(8'h50, 32'h3F);
        t = '{12'h56, 12'h34, 12'h12, 12'h15, 12'h06, 12'h123};
        strobe(t);
        chk("R4 global off", 32'(alarm_irq), 0);

        // R6 disabled field ignored: only minutes enabled, only seconds match
        wr(8'h50, 32'h42);
        t = '{12'h56, 12'h00, 12'h00, 12'h01, 12'h01, 12'h000};
        strobe(t);
        chk("R6 disabled field", 32'(alarm_irq), 0);

        // R7 matching fields without strobe
        wr(8'h50, 32'h7F);
        @(negedge clk);
        t = '{12'h56, 12'h34, 12'h12, 12'h15, 12'h06, 12'h123};
        set_time(t);
        repeat (4) @(negedge clk);
        chk("R7 no strobe", 32'(alarm_irq), 0);

        // R5 OR semantics: only hour matches
        t = '{12'h00, 12'h00, 12'h12, 12'h01, 12'h01, 12'h000};
        strobe(t);
        chk("R5 single field fires", 32'(alarm_irq), 1);

        // R8 held and visible in status
        repeat (5) @(negedge clk);
        chk("R8 held", 32'(alarm_irq), 1);
        rd(8'h30, d); chk("R8 status bit1", d, 32'h2);

        // R9 clear semantics
        wr(8'h30, 32'h1);
        chk("R9 write without bit1", 32'(alarm_irq), 1);
        wr(8'h30, 32'h2);
        chk("R9 clear", 32'(alarm_irq), 0);
        rd(8'h30, d); chk("R9 status cleared", d, 0);

        // R10 set wins over clear
        strobe(t);
        chk("R10 pre", 32'(alarm_irq), 1);
        @(negedge clk);
        set_time(t);
        tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = 8'h30; wr_data = 32'h2;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        chk("R10 set wins", 32'(alarm_irq), 1);
        wr(8'h30, 32'h2);

        // R11 year compares hundreds digit
        wr(8'h50, 32'h60);
        wr(8'h68, 32'h999);
        t = '{12'h00, 12'h00, 12'h00, 12'h01, 12'h01, 12'h199};
        strobe(t);
        chk("R11 hundreds differ", 32'(alarm_irq), 0);
        t[5] = 12'h999;
        strobe(t);
        chk("R11 year match", 32'(alarm_irq), 1);
        wr(8'h30, 32'h2);

        // random mix (R5 R6 R4)
        for (int it = 0; it < 300; it++) begin
            logic exp;
            for (int i = 0; i < 6; i++) wr(8'h54 + 8'(4*i), $urandom);
            d = $urandom;
            if ($urandom % 4 != 0) d[6] = 1'b1;
            wr(8'h50, d);
            wr(8'h30, 32'h2);
            for (int i = 0; i < 6; i++)
                t[i] = ($urandom % 3 == 0) ? m_alm[i] : (12'($urandom) & exp_mask(i));
            exp = exp_fire(m_ctrl, t);
            strobe(t);
            chk("R5 random fire", 32'(alarm_irq), 32'(exp));
        end

        finish_run();
    end

endmodule